// File: doc/BRIEF.md
# Interleaved ADC Timing-Skew Estimator

This block watches the output stream of a four-way time-interleaved ADC and works out, without any test tone, which channels sample too early or too late. Every incoming sample carries the index of the channel that produced it, and channels arrive in round-robin order. For each new sample the block takes its difference from the sample just before it, which came from the preceding channel. It then adds the magnitude of that difference to an accumulator kept for that channel pair. With a band-limited input, the mean magnitude of the step between two neighbouring channels grows with the real time gap between their sampling instants. Each pair's sum over a window is therefore a measure of that gap.

When a window closes, the block compares the gap ending at each channel with the gap starting at it. It then moves that channel's 6-bit delay-trim code one step toward equal spacing. Channel 0 is the fixed timing reference. The trim codes go to the variable delay buffers in the analog front end. A one-cycle strobe marks the cycle in which a fresh set of codes appears.

Top module: `skew_est_top`

## Requirements
- R1: While reset is held, every trim code is 32 and the update strobe is low. The first clock edge with reset asserted sets this state.
- R2: Samples are 12-bit two's complement. Pair k (k = 0..3) is the step from a channel k sample to the next sample, which comes from channel (k+1) mod 4. Its contribution is |new − previous|, and it is credited to pair (tag − 1) mod 4 of the new sample. The first valid sample after reset adds nothing.
- R3: A window closes on the edge that takes in its 4·2^WIN_LOG2-th difference. On the next edge the codes change and `trim_upd_o` rises for exactly one cycle.
- R4: All pair sums start from zero in each window. Nothing carries over from the window before.
- R5: The channel 0 code stays at 32 and never changes.
- R6: For channel j (1..3), take A = sum of pair j−1 and B = sum of pair j. If A > B + deadband, code j drops by one. If B > A + deadband, code j rises by one. Otherwise code j holds, so a gap equal to the deadband does not move the code. The deadband is the value on `deadband_i` at the update edge.
- R7: Codes saturate at 0 and 63 and never wrap.
- R8: Codes change only in the strobe cycle, and each code moves by at most one per strobe.
- R9: Cycles with `smp_valid_i` low have no effect on pairing, sums or window length. This holds whatever data and tag are present on those cycles.
- R10: In `trim_code_o`, channel c occupies bits [6c+5:6c]. A larger code means more delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid_i | input | 1 | Sample present this cycle |
| smp_chan_i | input | 2 | Channel index of the sample |
| smp_data_i | input | 12 | Sample, two's complement |
| deadband_i | input | ACC_W (24) | Minimum sum difference that causes a step |
| trim_code_o | output | 24 | Four 6-bit delay-trim codes, channel 0 in the low bits |
| trim_upd_o | output | 1 | One-cycle pulse when new codes appear |

## Verification
The bench targets four error classes. One is off-by-one pairing: a design that counted the first sample after reset against a zero history would move every later window boundary and credit a false step to pair 1. Another is deadband equality: a design using ≥ instead of > would step when the gap exactly equals the deadband. Saturation is driven at both ends by holding a lopsided pattern for forty windows, and a wrapping code would jump from 63 to 0. Idle cycles carry random garbage, and pattern switches are made without reset, so a design that let invalid data in or failed to clear its sums would show the wrong codes against the reference model.

// File: rtl/skew_pkg.sv
// Shared types for the timing-skew estimator.
package skew_pkg;
    // Direction decided for one channel at a window close
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;
endpackage

// File: rtl/skew_diff_abs.sv
// Magnitude of the step between two two's complement samples.
// Assumes both operands are DW-bit signed; the result fits DW bits unsigned.
module skew_diff_abs #(
    parameter int DW = 12
) (
    input  logic signed [DW-1:0] cur_i,
    input  logic signed [DW-1:0] prev_i,
    output logic        [DW-1:0] mag_o
);
    logic signed [DW:0] diff_w;
    logic signed [DW:0] neg_w;

    // Sign-extended subtraction, then magnitude
    always_comb begin
        diff_w = {cur_i[DW-1], cur_i} - {prev_i[DW-1], prev_i};
        neg_w  = -diff_w;
        mag_o  = diff_w[DW] ? neg_w[DW-1:0] : diff_w[DW-1:0];
    end
endmodule

// File: rtl/skew_accum.sv
// Per-pair magnitude accumulators with a snapshot taken at window close.
// Assumes close_i is only raised together with add_en_i (R3, R4).
module skew_accum #(
    parameter int NCH   = 4,
    parameter int DW    = 12,
    parameter int ACC_W = 24,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   add_en_i,
    input  logic                   close_i,
    input  logic [CH_W-1:0]        pair_i,
    input  logic [DW-1:0]          mag_i,
    output logic [NCH*ACC_W-1:0]   snap_o
);
    for (genvar k = 0; k < NCH; k++) begin : g_pair
        logic [ACC_W-1:0] acc_q;
        logic [ACC_W-1:0] snap_q;
        logic [ACC_W-1:0] addend_w;

        // Only the addressed pair receives the new magnitude
        always_comb addend_w = (pair_i == CH_W'(k)) ? ACC_W'(mag_i) : '0;

        // Accumulate; on close, publish the total and restart from zero
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc_q  <= '0;
                snap_q <= '0;
            end else if (add_en_i) begin
                if (close_i) begin
                    snap_q <= acc_q + addend_w;
                    acc_q  <= '0;
                end else begin
                    acc_q  <= acc_q + addend_w;
                end
            end
        end

        assign snap_o[k*ACC_W +: ACC_W] = snap_q;
    end
endmodule

// File: rtl/skew_trim_lane.sv
// Trim code for one non-reference channel. Compares the interval that ends
// at the channel with the interval that starts at it and moves the code by
// one step, saturating (R6, R7). Assumes apply_i is a single-cycle pulse.
module skew_trim_lane
    import skew_pkg::*;
#(
    parameter int ACC_W     = 24,
    parameter int CODE_W    = 6,
    parameter int CODE_INIT = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              apply_i,
    input  logic [ACC_W-1:0]  gap_in_i,
    input  logic [ACC_W-1:0]  gap_out_i,
    input  logic [ACC_W-1:0]  deadband_i,
    output logic [CODE_W-1:0] code_o
);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;

    logic [ACC_W:0]    in_lim_w;
    logic [ACC_W:0]    out_lim_w;
    step_e             step_w;
    logic [CODE_W-1:0] code_q;

    // Choose a direction; gaps equal within the deadband hold
    always_comb begin
        in_lim_w  = {1'b0, gap_in_i}  + {1'b0, deadband_i};
        out_lim_w = {1'b0, gap_out_i} + {1'b0, deadband_i};
        if ({1'b0, gap_in_i} > out_lim_w)
            step_w = STEP_DOWN;
        else if ({1'b0, gap_out_i} > in_lim_w)
            step_w = STEP_UP;
        else
            step_w = STEP_HOLD;
    end

    // Register the code, stepping once per window with saturation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= CODE_W'(CODE_INIT);
        end else if (apply_i) begin
            unique case (step_w)
                STEP_UP:   if (code_q != CODE_MAX) code_q <= code_q + 1'b1;
                STEP_DOWN: if (code_q != '0)       code_q <= code_q - 1'b1;
                default:   code_q <= code_q;
            endcase
        end
    end

    assign code_o = code_q;
endmodule

// File: rtl/skew_est_top.sv
// Blind timing-skew estimator for a round-robin interleaved ADC stream.
// Assumes NCH is a power of two and samples arrive tagged in channel order.
// Channel 0 is the timing reference; its code is fixed (R5).
module skew_est_top #(
    parameter int NCH       = 4,
    parameter int DW        = 12,
    parameter int WIN_LOG2  = 12,
    parameter int CODE_W    = 6,
    parameter int CODE_INIT = 32,
    parameter int ACC_W     = DW + WIN_LOG2,
    localparam int CH_W     = $clog2(NCH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid_i,
    input  logic [CH_W-1:0]          smp_chan_i,
    input  logic [DW-1:0]            smp_data_i,
    input  logic [ACC_W-1:0]         deadband_i,
    output logic [NCH*CODE_W-1:0]    trim_code_o,
    output logic                     trim_upd_o
);
    localparam int CNT_W = WIN_LOG2 + CH_W;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'((NCH << WIN_LOG2) - 1);

    logic signed [DW-1:0] prev_q;
    logic                 have_prev_q;
    logic [CNT_W-1:0]     cnt_q;
    logic                 done_q;
    logic                 upd_q;
    logic [DW-1:0]        mag_w;
    logic                 add_en_w;
    logic                 close_w;
    logic [CH_W-1:0]      pair_w;
    logic [NCH*ACC_W-1:0] snap_w;

    // Pair index is the channel before the new sample (R2)
    always_comb begin
        add_en_w = smp_valid_i && have_prev_q;
        close_w  = add_en_w && (cnt_q == CNT_LAST);
        pair_w   = smp_chan_i - 1'b1;
    end

    skew_diff_abs #(.DW(DW)) u_diff (
        .cur_i  (smp_data_i),
        .prev_i (prev_q),
        .mag_o  (mag_w)
    );

    // Remember the last valid sample; the first one only seeds history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q      <= '0;
            have_prev_q <= 1'b0;
        end else if (smp_valid_i) begin
            prev_q      <= smp_data_i;
            have_prev_q <= 1'b1;
        end
    end

    // Count differences in the current window (R3)
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (add_en_w)
            cnt_q <= close_w ? '0 : cnt_q + 1'b1;
    end

    // Delay the close into the apply pulse and the output strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            upd_q  <= 1'b0;
        end else begin
            done_q <= close_w;
            upd_q  <= done_q;
        end
    end

    skew_accum #(.NCH(NCH), .DW(DW), .ACC_W(ACC_W)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .add_en_i (add_en_w),
        .close_i  (close_w),
        .pair_i   (pair_w),
        .mag_i    (mag_w),
        .snap_o   (snap_w)
    );

    assign trim_code_o[CODE_W-1:0] = CODE_W'(CODE_INIT);

    for (genvar j = 1; j < NCH; j++) begin : g_lane
        skew_trim_lane #(
            .ACC_W     (ACC_W),
            .CODE_W    (CODE_W),
            .CODE_INIT (CODE_INIT)
        ) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .apply_i    (done_q),
            .gap_in_i   (snap_w[(j-1)*ACC_W +: ACC_W]),
            .gap_out_i  (snap_w[j*ACC_W +: ACC_W]),
            .deadband_i (deadband_i),
            .code_o     (trim_code_o[j*CODE_W +: CODE_W])
        );
    end

    assign trim_upd_o = upd_q;
endmodule

// File: rtl/skew_est_chk.sv
// Property checker for skew_est_top, attached by bind below.
module skew_est_chk #(
    parameter int NCH       = 4,
    parameter int CODE_W    = 6,
    parameter int CODE_INIT = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  smp_valid_i,
    input logic [NCH*CODE_W-1:0] trim_code_o,
    input logic                  trim_upd_o
);
    localparam logic [NCH*CODE_W-1:0] INIT_VEC = {NCH{CODE_W'(CODE_INIT)}};

    assert_reset_value_R1: assert property (@(posedge clk)
        !rst_n |=> (trim_code_o == INIT_VEC && !trim_upd_o));

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trim_upd_o |=> !trim_upd_o);

    assert_pulse_follows_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trim_upd_o |-> $past(smp_valid_i, 2));

    assert_hold_between_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !trim_upd_o |-> $stable(trim_code_o));

    for (genvar j = 1; j < NCH; j++) begin : g_step
        assert_unit_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
            trim_upd_o |->
                ({1'b0, trim_code_o[j*CODE_W +: CODE_W]} ==
                     {1'b0, $past(trim_code_o[j*CODE_W +: CODE_W])}) ||
                ({1'b0, trim_code_o[j*CODE_W +: CODE_W]} ==
                     {1'b0, $past(trim_code_o[j*CODE_W +: CODE_W])} + 1'b1) ||
                ({1'b0, trim_code_o[j*CODE_W +: CODE_W]} + 1'b1 ==
                     {1'b0, $past(trim_code_o[j*CODE_W +: CODE_W])}));
    end
endmodule

bind skew_est_top skew_est_chk #(
    .NCH       (NCH),
    .CODE_W    (CODE_W),
    .CODE_INIT (CODE_INIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_valid_i (smp_valid_i),
    .trim_code_o (trim_code_o),
    .trim_upd_o  (trim_upd_o)
);

// File: tb/tb_skew_est_top.sv
// Bench for skew_est_top: behavioural reference model compared every cycle,
// plus directed checks with literal expectations.
module tb_skew_est_top;
    localparam int NCH = 4, DW = 12, WL = 3, CW = 6, AW = DW + WL, CINIT = 32;
    localparam int WIN = NCH << WL;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          v = 1'b0;
    logic [1:0]    ch = '0;
    logic [DW-1:0] d = '0;
    logic [AW-1:0] db = '0;
    wire  [NCH*CW-1:0] code;
    wire               upd;

    skew_est_top #(.NCH(NCH), .DW(DW), .WIN_LOG2(WL), .CODE_W(CW), .CODE_INIT(CINIT)) dut (
        .clk(clk), .rst_n(rst_n), .smp_valid_i(v), .smp_chan_i(ch), .smp_data_i(d),
        .deadband_i(db), .trim_code_o(code), .trim_upd_o(upd)
    );

    int checks = 0, bad = 0, cyc = 0, nxt = 0;
    bit cmp_en = 0;
    int m_acc[4], m_snap[4], m_code[4];
    int m_cnt, m_prev, m_have, m_pend, m_upd;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int cget(input int j);
        return int'(code[j*CW +: CW]);
    endfunction

    // Reference model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 4; k++) begin m_acc[k] = 0; m_snap[k] = 0; m_code[k] = CINIT; end
            m_cnt = 0; m_prev = 0; m_have = 0; m_pend = 0; m_upd = 0;
        end else begin
            m_upd = 0;
            if (m_pend == 1) begin
                for (int j = 1; j < 4; j++) begin
                    if (m_snap[j-1] > m_snap[j] + int'(db)) m_code[j] = (m_code[j] > 0) ? m_code[j] - 1 : 0;
                    else if (m_snap[j] > m_snap[j-1] + int'(db)) m_code[j] = (m_code[j] < 63) ? m_code[j] + 1 : 63;
                end
                m_upd = 1; m_pend = 0;
            end
            if (v) begin
                int sv;
                int df;
                sv = int'(d);
                if (sv >= 2048) sv -= 4096;
                if (m_have == 1) begin
                    df = sv - m_prev;
                    if (df < 0) df = -df;
                    m_acc[(int'(ch) + 3) % 4] += df;
                    m_cnt++;
                    if (m_cnt == WIN) begin
                        for (int k = 0; k < 4; k++) begin m_snap[k] = m_acc[k]; m_acc[k] = 0; end
                        m_cnt = 0; m_pend = 1;
                    end
                end
                m_prev = sv; m_have = 1;
            end
        end
    end

    // Cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (cmp_en) begin
            check(upd == m_upd[0], "R3 strobe", int'(upd), m_upd);
            check(cget(0) == m_code[0], "R5 ch0 code", cget(0), m_code[0]);
            for (int j = 1; j < 4; j++)
                check(cget(j) == m_code[j], $sformatf("R6 code ch%0d", j), cget(j), m_code[j]);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++; bad++;
            $display("FAIL watchdog R3 act=%0d exp=<%0d", cyc, 100000);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    task automatic send(input int val);
        @(negedge clk);
        v = 1'b1; ch = 2'(nxt); d = DW'(val);
        nxt = (nxt + 1) % 4;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            v = 1'b0; ch = 2'($urandom_range(0, 3)); d = DW'($urandom_range(0, 4095));
        end
    endtask

    task automatic pattern(input int a0, input int a1, input int a2, input int a3,
                           input int n, input bit gaps);
        int p[4];
        p[0] = a0; p[1] = a1; p[2] = a2; p[3] = a3;
        for (int i = 0; i < n; i++) begin
            send(p[nxt]);
            if (gaps && (i % 2 == 0)) idle(1);
        end
        idle(3);
    endtask

    task automatic do_reset(input int start_ch);
        @(negedge clk);
        rst_n = 1'b0; v = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        nxt = start_ch;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cmp_en = 1;
        // R1: reset state
        for (int j = 0; j < 4; j++) check(cget(j) == 32, "R1 reset code", cget(j), 32);
        check(upd == 1'b0, "R1 reset strobe", int'(upd), 0);
        do_reset(0);

        // Pattern A: equal gaps except pair 3 long; ch3 climbs to the top (R7, R10)
        pattern(0, 100, 200, 300, 40 * WIN + 1, 0);
        check(cget(3) == 63, "R7 upper saturation ch3", cget(3), 63);
        check(cget(1) == 32, "R6 equal gaps hold ch1", cget(1), 32);
        check(cget(2) == 32, "R6 equal gaps hold ch2", cget(2), 32);
        check(cget(0) == 32, "R5 reference fixed", cget(0), 32);

        // Pattern B: ch1 and ch2 driven to 0, ch3 to 63
        do_reset(0);
        pattern(0, 300, 100, 200, 40 * WIN + 1, 0);
        check(cget(1) == 0, "R7 lower saturation ch1", cget(1), 0);
        check(cget(2) == 0, "R7 lower saturation ch2", cget(2), 0);
        check(cget(3) == 63, "R7 upper saturation ch3", cget(3), 63);

        // Deadband boundary: gap 1600 equal to deadband holds, 1599 steps (R6)
        do_reset(0);
        db = AW'(1600);
        pattern(0, 100, 200, 300, 5 * WIN + 1, 0);
        check(cget(3) == 32, "R6 deadband equal holds", cget(3), 32);
        db = AW'(1599);
        pattern(0, 100, 200, 300, 3 * WIN, 0);
        check(cget(3) == 35, "R6 deadband exceeded steps", cget(3), 35);

        // R2 first sample seeds only; R9 gaps with garbage; start at ch2
        db = '0;
        do_reset(2);
        pattern(0, 300, 100, 200, 2 * WIN + 1, 1);
        check(cget(1) == 30, "R9 gaps ignored ch1", cget(1), 30);
        check(cget(2) == 30, "R2 pairing ch2", cget(2), 30);
        check(cget(3) == 34, "R2 pairing ch3", cget(3), 34);

        // R4: switch pattern without reset; stale sums would mislead
        pattern(0, 100, 200, 300, 3 * WIN, 0);
        check(cget(1) == 30, "R4 fresh window ch1", cget(1), 30);
        check(cget(3) == 37, "R4 fresh window ch3", cget(3), 37);

        // Signed random data, random gaps and deadband (R2, R6, R9)
        do_reset(0);
        for (int i = 0; i < 20 * WIN; i++) begin
            if ($urandom_range(0, 3) == 0) idle(1);
            db = AW'($urandom_range(0, 3000));
            send(int'($urandom_range(0, 4095)));
        end
        idle(4);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule